// File: doc/BRIEF.md
# Hot-Plug Status and Interrupt Controller

This block watches two connection-sense inputs of a display link transmitter. One is the hot-plug sense line from the display connector. It is synchronised and then digitally debounced. The other is the receiver-present indication taken from the link clock pair, which is only synchronised. The live state of both inputs can be read from a status register. Any change of either state, rising or falling, latches a sticky event bit. Each event type has its own enable bit, and the enables gate only the single active-high interrupt pin.

A host reads and writes the three registers through a plain synchronous register port: a one-cycle write strobe with subaddress and write data, and a combinational read data bus that follows the subaddress. The host clears an event bit by writing 1 to it. It can either poll the event register or rely on the interrupt pin. Nothing in the port is a data stream, so it carries no valid/ready handshake and has no back-pressure: every write strobe takes effect in the cycle it is sampled.

Top module: `hpd_irq_ctrl`

## Requirements
- R1: Subaddress 0x3E is read-only. It returns the synchronised receiver-present state in bit 0 and the debounced hot-plug state in bit 1. Bits 7..2 read 0, and writes to 0x3E change nothing.
- R2: The debounced hot-plug state takes a new value only after the synchronised sense line has differed from it for DB_CYCLES consecutive clocks. With DB_CYCLES = 6, a raw change becomes visible at 0x3E on the 8th rising edge after it is applied. A pulse of 4 cycles or less is never seen.
- R3: Every change of a status bit, in either direction, sets the matching event bit at 0x3F (bit 0 receiver, bit 1 hot-plug) one clock after the status changes. Event bits hold until they are cleared.
- R4: Event bits latch whether or not their enable bit is set.
- R5: Writing 1 to an event bit clears it. Writing 0 to an event bit leaves it unchanged.
- R6: When a status change and a write-1 clear hit the same event bit in the same cycle, the bit ends at 1.
- R7: Subaddress 0x40 holds the enables (bit 0 receiver, bit 1 hot-plug) and reads back what was written. Its bits 7..2 read 0.
- R8: irq_o is high exactly when, one clock earlier, some event bit and its enable were both 1.
- R9: After reset, the event bits, the enables and irq_o are 0. Inputs that are already high while reset is active cause no event when reset is released, and they appear in the status register.
- R10: Any subaddress other than 0x3E, 0x3F and 0x40 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hp_sense_i | input | 1 | Raw hot-plug sense line, asynchronous |
| rx_sense_i | input | 1 | Receiver-present indication, asynchronous |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 8 | Register subaddress for reads and writes |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Active-high interrupt, registered |

## Verification
The assertions assume the following about the inputs:
- The write strobe, subaddress and write data are synchronous to clk_i and settled around every rising edge.
- The two sense inputs may change at any time, because only the synchroniser samples them.

The bench keeps within these assumptions by changing every input on the falling clock edge and holding each write strobe for exactly one cycle. It times a receiver change so that its event arrives in the same cycle as a clearing write, which exercises the collision case. It also drives hot-plug pulses shorter than the debounce window, and checks that they leave the status and event registers unchanged.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_RX  = 0;
  localparam int unsigned SRC_HP  = 1;

  localparam logic [ADDR_W-1:0] SUB_STATUS = 8'h3E;
  localparam logic [ADDR_W-1:0] SUB_EVENT  = 8'h3F;
  localparam logic [ADDR_W-1:0] SUB_ENABLE = 8'h40;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hpd_debounce.sv
module hpd_debounce #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic seed_i,
  input  logic in_i,
  output logic out_o
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (seed_i) begin
      out_q <= in_i;
      cnt_q <= '0;
    end else if (in_i != out_q) begin
      if (cnt_q == LAST) begin
        out_q <= in_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/hpd_event_bank.sv
module hpd_event_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         arm_i,
  input  logic [N-1:0] cur_i,
  input  logic [N-1:0] clr_i,
  input  logic         en_wr_i,
  input  logic [N-1:0] en_wdata_i,
  output logic [N-1:0] set_o,
  output logic [N-1:0] evt_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  logic [N-1:0] prev_q, evt_q, en_q;
  logic         irq_q;

  // An event is seen only once the trackers have been seeded.
  assign set_o = arm_i ? (cur_i ^ prev_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      evt_q  <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= cur_i;
      evt_q  <= (evt_q & ~clr_i) | set_o;
      if (en_wr_i) en_q <= en_wdata_i;
      irq_q  <= |(evt_q & en_q);
    end
  end

  assign evt_o = evt_q;
  assign en_o  = en_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/hpd_irq_ctrl.sv
module hpd_irq_ctrl
  import hpd_pkg::*;
#(
  parameter int unsigned DB_CYCLES   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hp_sense_i,
  input  logic              rx_sense_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned PRIME_CYC = SYNC_STAGES + 2;
  localparam int unsigned PW = $clog2(PRIME_CYC + 1);
  localparam logic [PW-1:0] PRIME_END = PW'(PRIME_CYC);
  localparam int unsigned PAD = DATA_W - NUM_SRC;

  src_vec_t raw, sync_bus, status, clr, set, evt, en;
  logic     hp_db;
  logic     arm;
  logic [PW-1:0] prime_q;

  assign raw[SRC_RX] = rx_sense_i;
  assign raw[SRC_HP] = hp_sense_i;

  hpd_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(sync_bus)
  );

  // Seeding window after reset: the sync pipe fills, then the debouncer and
  // the change trackers copy the inputs so that nothing fires.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prime_q <= '0;
    else if (prime_q != PRIME_END) prime_q <= prime_q + 1'b1;
  end
  assign arm = (prime_q == PRIME_END);

  hpd_debounce #(.CYCLES(DB_CYCLES)) deb_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .seed_i(!arm),
    .in_i(sync_bus[SRC_HP]), .out_o(hp_db)
  );

  assign status[SRC_RX] = sync_bus[SRC_RX];
  assign status[SRC_HP] = hp_db;

  assign clr = (reg_wr_i && reg_addr_i == SUB_EVENT) ? reg_wdata_i[NUM_SRC-1:0] : '0;

  hpd_event_bank #(.N(NUM_SRC)) bank_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm), .cur_i(status),
    .clr_i(clr), .en_wr_i(reg_wr_i && reg_addr_i == SUB_ENABLE),
    .en_wdata_i(reg_wdata_i[NUM_SRC-1:0]),
    .set_o(set), .evt_o(evt), .en_o(en), .irq_o(irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      SUB_STATUS: reg_rdata_o = {{PAD{1'b0}}, status};
      SUB_EVENT:  reg_rdata_o = {{PAD{1'b0}}, evt};
      SUB_ENABLE: reg_rdata_o = {{PAD{1'b0}}, en};
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/hpd_irq_ctrl_chk.sv
module hpd_irq_ctrl_chk
  import hpd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_i,
  input logic              irq_i,
  input logic [NUM_SRC-1:0] evt_i,
  input logic [NUM_SRC-1:0] en_i,
  input logic [NUM_SRC-1:0] set_i,
  input logic              hp_db_i,
  input logic              hp_sync_i
);
  logic [NUM_SRC-1:0] clr_v;
  logic               mapped;
  assign clr_v  = (wr_i && addr_i == SUB_EVENT) ? wdata_i[NUM_SRC-1:0] : '0;
  assign mapped = (addr_i == SUB_STATUS) || (addr_i == SUB_EVENT) || (addr_i == SUB_ENABLE);

  assert_upper_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_i[DATA_W-1:NUM_SRC] == '0);

  assert_db_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hp_db_i != $past(hp_db_i)) |-> (hp_db_i == $past(hp_sync_i)));

  assert_evt_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(evt_i) & ~$past(clr_v) & ~evt_i) == '0));

  assert_evt_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_v) |=> ((evt_i & $past(clr_v) & ~$past(set_i)) == '0));

  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((evt_i & $past(set_i)) == $past(set_i)));

  assert_enable_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == SUB_ENABLE) |=> (en_i == $past(wdata_i[NUM_SRC-1:0])));

  assert_irq_lag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i == $past(|(evt_i & en_i)));

  assert_unmapped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> (rdata_i == '0));
endmodule

bind hpd_irq_ctrl hpd_irq_ctrl_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
  .wdata_i(reg_wdata_i), .rdata_i(reg_rdata_o), .irq_i(irq_o),
  .evt_i(evt), .en_i(en), .set_i(set), .hp_db_i(hp_db),
  .hp_sync_i(sync_bus[hpd_pkg::SRC_HP])
);

// File: tb/hpd_irq_ctrl_tb_top.sv
module hpd_irq_ctrl_tb_top;
  localparam int unsigned DB = 6;
  localparam int unsigned NV = 10;
  // {write, subaddress, write data, expected read}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h40, 8'hFF, 8'h03},  // R7
    {1'b1, 8'h40, 8'h02, 8'h02},  // R7
    {1'b1, 8'h40, 8'h01, 8'h01},  // R7
    {1'b0, 8'h41, 8'h00, 8'h00},  // R10
    {1'b0, 8'h00, 8'h00, 8'h00},  // R10
    {1'b0, 8'hFF, 8'h00, 8'h00},  // R10
    {1'b1, 8'h3E, 8'hFF, 8'h00},  // R1 write ignored
    {1'b1, 8'h3F, 8'hFF, 8'h00},  // R5 clear of idle bits
    {1'b1, 8'h40, 8'h00, 8'h00},  // R7
    {1'b0, 8'h3D, 8'h00, 8'h00}   // R10
  };

  logic clk = 1'b0, rst_n = 1'b0, hp = 1'b0, rx = 1'b0, wr = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic irq;
  int n_run = 0, n_fail = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  hpd_irq_ctrl #(.DB_CYCLES(DB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hp_sense_i(hp), .rx_sense_i(rx),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(2 * DB + 10);
  endtask

  initial begin
    #(20 * 50000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R9: reset state
    idle(2);
    chk("R9 irq in reset", {7'b0, irq}, 8'h00);
    do_reset();
    rd(8'h3F, v); chk("R9 events", v, 8'h00);
    rd(8'h40, v); chk("R9 enables", v, 8'h00);
    chk("R9 irq", {7'b0, irq}, 8'h00);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) wreg(VEC[i][23:16], VEC[i][15:8]);
      rd(VEC[i][23:16], v);
      chk($sformatf("R1/R5/R7/R10 vector %0d", i), v, VEC[i][7:0]);
      idle(1);
    end

    // R9: inputs high across reset give status but no event
    rx = 1'b1; hp = 1'b1;
    do_reset();
    rd(8'h3E, v); chk("R1 R9 status", v, 8'h03);
    rd(8'h3F, v); chk("R9 no event at release", v, 8'h00);

    // R3 R4: receiver drop with enable off
    rx = 1'b0; idle(5);
    rd(8'h3E, v); chk("R1 rx low", v, 8'h02);
    rd(8'h3F, v); chk("R3 R4 rx event", v, 8'h01);
    chk("R8 irq gated", {7'b0, irq}, 8'h00);

    // R8: enable, irq one clock after the enable lands
    wreg(8'h40, 8'h01);
    chk("R8 irq not yet", {7'b0, irq}, 8'h00);
    idle(1);
    chk("R8 irq high", {7'b0, irq}, 8'h01);

    // R5: write 0 no effect, write 1 clears
    wreg(8'h3F, 8'h00);
    rd(8'h3F, v); chk("R5 write zero", v, 8'h01);
    wreg(8'h3F, 8'h01);
    rd(8'h3F, v); chk("R5 write one", v, 8'h00);
    idle(1);
    chk("R8 irq drops", {7'b0, irq}, 8'h00);

    // R2: debounce timing on falling hot-plug
    hp = 1'b0; idle(DB + 1);
    rd(8'h3E, v); chk("R2 before window", v, 8'h02);
    idle(1);
    rd(8'h3E, v); chk("R2 after window", v, 8'h00);
    idle(1);
    rd(8'h3F, v); chk("R3 hp falling event", v, 8'h02);
    wreg(8'h3F, 8'h02);

    // R2: short glitch ignored
    hp = 1'b1; idle(DB - 2); hp = 1'b0; idle(3 * DB);
    rd(8'h3E, v); chk("R2 glitch status", v, 8'h00);
    rd(8'h3F, v); chk("R2 glitch event", v, 8'h00);

    // R3 R8: hot-plug rising with enable
    wreg(8'h40, 8'h02);
    hp = 1'b1; idle(DB + 5);
    rd(8'h3F, v); chk("R3 hp rising event", v, 8'h02);
    chk("R8 hp irq", {7'b0, irq}, 8'h01);
    wreg(8'h3F, 8'h02);
    wreg(8'h40, 8'h00);

    // R6: set and clear collide
    rx = 1'b1; idle(5);
    rd(8'h3F, v); chk("R3 rx rising", v, 8'h01);
    rx = 1'b0; idle(2);
    wreg(8'h3F, 8'h01);
    rd(8'h3F, v); chk("R6 set wins", v, 8'h01);
    wreg(8'h3F, 8'h01);
    rd(8'h3F, v); chk("R5 clear after collision", v, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule